// File: doc/BRIEF.md
# Run-Time Selected Stream Put Unit

This unit carries out a processor's "write a word to a stream link" operation when the link is not fixed in the instruction but taken from a register at run time. The pipeline hands it one operation at a time: a data word, a selector word whose low four bits name the target link, and four modifier flags. The modifiers pick blocking or non-blocking behaviour, a data or a control beat, a probe that writes nothing, and atomic behaviour. Each link is an AXI4-Stream master fed by a one-beat output register. A link has space when that register is empty or is being drained by the consumer in the same cycle.

A blocking put with no space raises a stall and waits. It completes when the link frees, or it is withdrawn if an interrupt may be taken first. A non-blocking put always finishes at once and reports the space it found in a carry flag. A selector beyond the configured link count either raises an illegal-instruction trap or retires as a no-op, as a parameter chooses. An atomic put asserts an interrupt-inhibit that lasts until the next instruction retires. A chain of atomic puts therefore cannot be split by an interrupt.

Top module: `sput_link_unit`

## Requirements
- R1: The target link is op_rs2[3:0]; bits of op_rs2 above bit 3 have no effect on which link is written.
- R2: With TWO_CYCLE=0, a legal blocking put that finds space raises op_done one cycle after op_valid, and in that same cycle m_tvalid shows only the selected link set, with m_tdata of that link equal to op_rs1.
- R3: The selected link's m_tlast equals op_ctrl for the beat it carries: 1 for a control put, 0 for a data put.
- R4: A blocking put that finds no space holds stall high and leaves the link's pending beat untouched until the link frees. It then loads its own beat and raises op_done in the cycle stall falls.
- R5: A non-blocking put never raises stall. It completes with carry_we=1 and carry_val=0 when the link had space (and loads the beat), or carry_val=1 when it had none (and loads nothing). A link whose beat is accepted in the issue cycle counts as having space.
- R6: A test put (op_test=1) reports completion and carry exactly as a normal put would, but loads no beat: no m_tvalid rises and m_tdata/m_tlast of the link keep their values.
- R7: With a selector at or above NLINK, the unit with ILL_MODE=2 raises trap_req with trap_cause=2 and no op_done. With any other ILL_MODE it raises op_done only. In both cases no link is written.
- R8: An atomic put drives irq_inhibit high while it is stalled and from its completion until insn_retire is pulsed. No op_abort is raised while irq_inhibit is high.
- R9: During a blocking stall, irq_req with EXT_EN=1, a non-atomic put and irq_inhibit low withdraws the put: op_abort is pulsed, stall falls and no beat is loaded. If the link frees in the same cycle, the put completes instead.
- R10: With EXT_EN=0, op_test and op_atomic are ignored and the put behaves as a plain put.
- R11: With TWO_CYCLE=1 every result appears two cycles after op_valid instead of one.
- R12: A link's m_tvalid, m_tdata and m_tlast stay stable while m_tvalid is high and m_tready is low. No more than one link raises m_tvalid in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | One-cycle pulse issuing a put (only while no put is in progress) |
| op_rs1 | input | DATA_W | Data word to send |
| op_rs2 | input | DATA_W | Selector word; bits 3:0 pick the link |
| op_nb | input | 1 | 1 = non-blocking |
| op_ctrl | input | 1 | 1 = control beat (TLAST high) |
| op_test | input | 1 | 1 = probe only, no beat |
| op_atomic | input | 1 | 1 = atomic |
| irq_req | input | 1 | Interrupt controller wishes to take an interrupt |
| insn_retire | input | 1 | Pulse when another instruction retires |
| m_tready | input | NLINK | Per-link TREADY |
| m_tvalid | output | NLINK | Per-link TVALID |
| m_tlast | output | NLINK | Per-link TLAST |
| m_tdata | output | NLINK x DATA_W | Per-link TDATA |
| stall | output | 1 | Pipeline must wait |
| op_done | output | 1 | Put completed |
| op_abort | output | 1 | Put withdrawn for an interrupt |
| carry_we | output | 1 | Write carry status flag |
| carry_val | output | 1 | Carry value (1 = no space) |
| trap_req | output | 1 | Illegal-instruction trap request |
| trap_cause | output | 4 | Trap cause code (2 when trap_req) |
| irq_inhibit | output | 1 | External interrupts and breaks must not be taken |

## Verification
Two events can meet in one cycle of a blocking stall: the consumer accepting the old beat and the interrupt controller asking to withdraw the put. The bench stalls a put on a full link, then raises irq_req and the link's m_tready at the same falling edge. It expects op_done, no op_abort, and the new word on the link. A separate run raises irq_req alone and expects op_abort with the old word kept. A non-blocking put issued while the consumer drains the same link is a second such meeting point, and it must report a carry of 0.

// File: rtl/sput_pkg.sv
package sput_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } sput_state_e;

    typedef struct packed {
        logic nb;
        logic ctrl;
        logic test;
        logic atomic;
    } sput_flags_t;

    localparam int unsigned SEL_W         = 4;
    localparam int unsigned SEL_SPAN      = 1 << SEL_W;
    localparam logic [3:0]  CAUSE_ILLEGAL = 4'd2;

endpackage

// File: rtl/sput_link_slot.sv
module sput_link_slot #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_last,
    input  logic              tready,
    output logic              tvalid,
    output logic              tlast,
    output logic [DATA_W-1:0] tdata,
    output logic              space
);

    typedef struct packed {
        logic              valid;
        logic              last;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.valid && tready) begin
            slot_d.valid = 1'b0;
        end
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.last  = load_last;
            slot_d.data  = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign space  = !slot_q.valid || tready;
    assign tvalid = slot_q.valid;
    assign tlast  = slot_q.last;
    assign tdata  = slot_q.data;

endmodule

// File: rtl/sput_ctrl.sv
module sput_ctrl
    import sput_pkg::*;
#(
    parameter int unsigned NLINK    = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ILL_MODE = 2,
    parameter int unsigned EXT_EN   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] go_data,
    input  logic [SEL_W-1:0]  go_sel,
    input  sput_flags_t       go_flags,
    input  logic [NLINK-1:0]  link_space,
    input  logic              irq_req,
    input  logic              insn_retire,
    output logic [NLINK-1:0]  load,
    output logic [DATA_W-1:0] load_data,
    output logic              load_last,
    output logic              stall,
    output logic              done,
    output logic              abort,
    output logic              carry_we,
    output logic              carry_val,
    output logic              trap_req,
    output logic [3:0]        trap_cause,
    output logic              irq_inhibit
);

    localparam logic [SEL_W:0] LINK_LIMIT = (SEL_W + 1)'(NLINK);
    localparam bit             TRAP_ON    = (ILL_MODE == 2);
    localparam bit             EXT_ON     = (EXT_EN != 0);

    typedef struct packed {
        sput_state_e       state;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] data;
        sput_flags_t       flags;
        logic              done;
        logic              abort;
        logic              carry_we;
        logic              carry;
        logic              trap;
        logic              inhibit;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [SEL_SPAN-1:0] space_all;
    logic [SEL_SPAN-1:0] load_all;
    sput_flags_t         eff;
    logic                go_legal;
    logic                irq_ok;

    assign space_all = SEL_SPAN'(link_space);
    assign go_legal  = ({1'b0, go_sel} < LINK_LIMIT);
    assign irq_ok    = irq_req && EXT_ON && !ctrl_q.flags.atomic && !ctrl_q.inhibit;

    always_comb begin
        eff = go_flags;
        if (!EXT_ON) begin
            eff.test   = 1'b0;
            eff.atomic = 1'b0;
        end
    end

    always_comb begin
        ctrl_d          = ctrl_q;
        ctrl_d.done     = 1'b0;
        ctrl_d.abort    = 1'b0;
        ctrl_d.carry_we = 1'b0;
        ctrl_d.trap     = 1'b0;
        if (insn_retire) begin
            ctrl_d.inhibit = 1'b0;
        end
        load_all  = '0;
        load_data = ctrl_q.data;
        load_last = ctrl_q.flags.ctrl;

        case (ctrl_q.state)
            ST_IDLE: begin
                if (go) begin
                    if (!go_legal) begin
                        ctrl_d.inhibit = 1'b0;
                        if (TRAP_ON) begin
                            ctrl_d.trap = 1'b1;
                        end else begin
                            ctrl_d.done = 1'b1;
                        end
                    end else if (space_all[go_sel] || eff.nb) begin
                        ctrl_d.done    = 1'b1;
                        ctrl_d.inhibit = eff.atomic;
                        if (eff.nb) begin
                            ctrl_d.carry_we = 1'b1;
                            ctrl_d.carry    = !space_all[go_sel];
                        end
                        load_data = go_data;
                        load_last = eff.ctrl;
                        if (space_all[go_sel] && !eff.test) begin
                            load_all[go_sel] = 1'b1;
                        end
                    end else begin
                        ctrl_d.state = ST_WAIT;
                        ctrl_d.sel   = go_sel;
                        ctrl_d.data  = go_data;
                        ctrl_d.flags = eff;
                    end
                end
            end
            ST_WAIT: begin
                if (space_all[ctrl_q.sel]) begin
                    ctrl_d.state   = ST_IDLE;
                    ctrl_d.done    = 1'b1;
                    ctrl_d.inhibit = ctrl_q.flags.atomic;
                    load_all[ctrl_q.sel] = !ctrl_q.flags.test;
                end else if (irq_ok) begin
                    ctrl_d.state = ST_IDLE;
                    ctrl_d.abort = 1'b1;
                end
            end
            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign load        = load_all[NLINK-1:0];
    assign stall       = (ctrl_q.state == ST_WAIT);
    assign done        = ctrl_q.done;
    assign abort       = ctrl_q.abort;
    assign carry_we    = ctrl_q.carry_we;
    assign carry_val   = ctrl_q.carry;
    assign trap_req    = ctrl_q.trap;
    assign trap_cause  = ctrl_q.trap ? CAUSE_ILLEGAL : 4'd0;
    assign irq_inhibit = ctrl_q.inhibit || (stall && ctrl_q.flags.atomic);

endmodule

// File: rtl/sput_link_unit.sv
module sput_link_unit
    import sput_pkg::*;
#(
    parameter int unsigned NLINK     = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ILL_MODE  = 2,
    parameter int unsigned EXT_EN    = 1,
    parameter int unsigned TWO_CYCLE = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic [DATA_W-1:0]           op_rs1,
    input  logic [DATA_W-1:0]           op_rs2,
    input  logic                        op_nb,
    input  logic                        op_ctrl,
    input  logic                        op_test,
    input  logic                        op_atomic,
    input  logic                        irq_req,
    input  logic                        insn_retire,
    input  logic [NLINK-1:0]            m_tready,
    output logic [NLINK-1:0]            m_tvalid,
    output logic [NLINK-1:0]            m_tlast,
    output logic [NLINK-1:0][DATA_W-1:0] m_tdata,
    output logic                        stall,
    output logic                        op_done,
    output logic                        op_abort,
    output logic                        carry_we,
    output logic                        carry_val,
    output logic                        trap_req,
    output logic [3:0]                  trap_cause,
    output logic                        irq_inhibit
);

    if (NLINK < 1 || NLINK > SEL_SPAN) begin : g_bad_links
        $error("sput_link_unit: NLINK out of range");
    end

    sput_flags_t        op_flags;
    logic               go;
    logic [DATA_W-1:0]  go_data;
    logic [SEL_W-1:0]   go_sel;
    sput_flags_t        go_flags;
    logic [NLINK-1:0]   link_space;
    logic [NLINK-1:0]   load;
    logic [DATA_W-1:0]  load_data;
    logic               load_last;
    logic               unused_sel_hi;

    assign op_flags      = '{nb: op_nb, ctrl: op_ctrl, test: op_test, atomic: op_atomic};
    assign unused_sel_hi = ^op_rs2[DATA_W-1:SEL_W];

    if (TWO_CYCLE != 0) begin : g_stage
        typedef struct packed {
            logic              vld;
            logic [SEL_W-1:0]  sel;
            logic [DATA_W-1:0] data;
            sput_flags_t       flags;
        } stage_t;

        stage_t stage_d, stage_q;

        always_comb begin
            stage_d.vld   = op_valid;
            stage_d.sel   = op_rs2[SEL_W-1:0];
            stage_d.data  = op_rs1;
            stage_d.flags = op_flags;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= '0;
            end else begin
                stage_q <= stage_d;
            end
        end

        assign go       = stage_q.vld;
        assign go_sel   = stage_q.sel;
        assign go_data  = stage_q.data;
        assign go_flags = stage_q.flags;
    end else begin : g_direct
        assign go       = op_valid;
        assign go_sel   = op_rs2[SEL_W-1:0];
        assign go_data  = op_rs1;
        assign go_flags = op_flags;
    end

    sput_ctrl #(
        .NLINK    (NLINK),
        .DATA_W   (DATA_W),
        .ILL_MODE (ILL_MODE),
        .EXT_EN   (EXT_EN)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .go_data     (go_data),
        .go_sel      (go_sel),
        .go_flags    (go_flags),
        .link_space  (link_space),
        .irq_req     (irq_req),
        .insn_retire (insn_retire),
        .load        (load),
        .load_data   (load_data),
        .load_last   (load_last),
        .stall       (stall),
        .done        (op_done),
        .abort       (op_abort),
        .carry_we    (carry_we),
        .carry_val   (carry_val),
        .trap_req    (trap_req),
        .trap_cause  (trap_cause),
        .irq_inhibit (irq_inhibit)
    );

    for (genvar i = 0; i < NLINK; i++) begin : g_link
        sput_link_slot #(
            .DATA_W (DATA_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load[i]),
            .load_data (load_data),
            .load_last (load_last),
            .tready    (m_tready[i]),
            .tvalid    (m_tvalid[i]),
            .tlast     (m_tlast[i]),
            .tdata     (m_tdata[i]),
            .space     (link_space[i])
        );
    end

endmodule

// File: rtl/sput_link_unit_chk.sv
module sput_link_unit_chk #(
    parameter int unsigned NLINK     = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned TWO_CYCLE = 0
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         op_valid,
    input logic                         op_nb,
    input logic                         stall,
    input logic                         op_done,
    input logic                         op_abort,
    input logic                         carry_we,
    input logic                         trap_req,
    input logic                         irq_inhibit,
    input logic [NLINK-1:0]             m_tvalid,
    input logic [NLINK-1:0]             m_tready,
    input logic [NLINK-1:0]             m_tlast,
    input logic [NLINK-1:0][DATA_W-1:0] m_tdata
);

    for (genvar i = 0; i < NLINK; i++) begin : g_hold
        assert_beat_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (m_tvalid[i] && !m_tready[i]) |=>
                (m_tvalid[i] && $stable(m_tdata[i]) && $stable(m_tlast[i])));
    end

    assert_single_new_beat_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(m_tvalid & ~$past(m_tvalid)) <= 1);

    assert_trap_no_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (((m_tvalid & ~$past(m_tvalid)) == '0) && !op_done));

    assert_stall_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (op_done || op_abort));

    assert_no_abort_inhibited_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_abort |-> !$past(irq_inhibit));

    assert_carry_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        carry_we |-> (op_done && !stall));

    if (TWO_CYCLE != 0) begin : g_nb_slow
        assert_nb_never_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op_nb && !stall) |=> ##1 !stall);
    end else begin : g_nb_fast
        assert_nb_never_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op_nb && !stall) |=> !stall);
    end

endmodule

bind sput_link_unit sput_link_unit_chk #(
    .NLINK     (NLINK),
    .DATA_W    (DATA_W),
    .TWO_CYCLE (TWO_CYCLE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_nb       (op_nb),
    .stall       (stall),
    .op_done     (op_done),
    .op_abort    (op_abort),
    .carry_we    (carry_we),
    .trap_req    (trap_req),
    .irq_inhibit (irq_inhibit),
    .m_tvalid    (m_tvalid),
    .m_tready    (m_tready),
    .m_tlast     (m_tlast),
    .m_tdata     (m_tdata)
);

// File: tb/sput_link_unit_test.sv
module sput_link_unit_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    logic             op_valid = 0, op_nb = 0, op_ctrl = 0, op_test = 0, op_atomic = 0;
    logic [31:0]      op_rs1 = 0, op_rs2 = 0;
    logic             irq_req = 0, insn_retire = 0;
    logic [3:0]       rdy = 0;
    logic [3:0]       m_tvalid, m_tlast;
    logic [3:0][31:0] m_tdata;
    logic             stall, op_done, op_abort, carry_we, carry_val, trap_req, irq_inhibit;
    logic [3:0]       trap_cause;

    sput_link_unit #(.NLINK(4), .DATA_W(32), .ILL_MODE(2), .EXT_EN(1), .TWO_CYCLE(0)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_rs1(op_rs1), .op_rs2(op_rs2),
        .op_nb(op_nb), .op_ctrl(op_ctrl), .op_test(op_test), .op_atomic(op_atomic),
        .irq_req(irq_req), .insn_retire(insn_retire), .m_tready(rdy),
        .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tdata(m_tdata), .stall(stall),
        .op_done(op_done), .op_abort(op_abort), .carry_we(carry_we), .carry_val(carry_val),
        .trap_req(trap_req), .trap_cause(trap_cause), .irq_inhibit(irq_inhibit));

    logic             a_valid = 0, a_test = 0, a_atomic = 0;
    logic [15:0]      a_rs1 = 0, a_rs2 = 0;
    logic [1:0]       a_rdy = 0;
    logic [1:0]       a_tvalid, a_tlast;
    logic [1:0][15:0] a_tdata;
    logic             a_stall, a_done, a_abort, a_cwe, a_carry, a_trap, a_inhibit;
    logic [3:0]       a_cause;

    sput_link_unit #(.NLINK(2), .DATA_W(16), .ILL_MODE(0), .EXT_EN(0), .TWO_CYCLE(1)) uut_alt (
        .clk(clk), .rst_n(rst_n), .op_valid(a_valid), .op_rs1(a_rs1), .op_rs2(a_rs2),
        .op_nb(1'b0), .op_ctrl(1'b0), .op_test(a_test), .op_atomic(a_atomic),
        .irq_req(1'b0), .insn_retire(1'b0), .m_tready(a_rdy),
        .m_tvalid(a_tvalid), .m_tlast(a_tlast), .m_tdata(a_tdata), .stall(a_stall),
        .op_done(a_done), .op_abort(a_abort), .carry_we(a_cwe), .carry_val(a_carry),
        .trap_req(a_trap), .trap_cause(a_cause), .irq_inhibit(a_inhibit));

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge; returns one falling edge later
    task automatic put(input logic [31:0] rs1, input logic [31:0] rs2,
                       input bit nb, input bit ctl, input bit tst, input bit atm);
        op_valid = 1; op_rs1 = rs1; op_rs2 = rs2;
        op_nb = nb; op_ctrl = ctl; op_test = tst; op_atomic = atm;
        @(negedge clk);
        op_valid = 0; op_nb = 0; op_ctrl = 0; op_test = 0; op_atomic = 0;
    endtask

    task automatic drain();
        rdy = 4'hF;
        @(negedge clk);
        rdy = 4'h0;
    endtask

    task automatic t_reset();
        check("R12", "tvalid after reset", 64'(m_tvalid), 64'h0);
        check("R4", "stall after reset", 64'(stall), 64'h0);
        check("R8", "inhibit after reset", 64'(irq_inhibit), 64'h0);
        check("R2", "done after reset", 64'(op_done), 64'h0);
    endtask

    task automatic t_basic();
        put(32'hDEADBEEF, 32'hABC0_0002, 0, 1, 0, 0);
        check("R2", "done", 64'(op_done), 64'h1);
        check("R1", "only link 2 valid", 64'(m_tvalid), 64'h4);
        check("R2", "tdata link 2", 64'(m_tdata[2]), 64'hDEADBEEF);
        check("R3", "tlast control put", 64'(m_tlast[2]), 64'h1);
        check("R2", "no stall", 64'(stall), 64'h0);
        @(negedge clk);
        check("R12", "beat held", 64'(m_tvalid), 64'h4);
        check("R12", "data held", 64'(m_tdata[2]), 64'hDEADBEEF);
        drain();
        check("R12", "beat accepted", 64'(m_tvalid), 64'h0);
        put(32'h11, 32'hFFFF_FFF1, 0, 0, 0, 0);
        check("R1", "link 1 from low bits", 64'(m_tvalid), 64'h2);
        check("R3", "tlast data put", 64'(m_tlast[1]), 64'h0);
        drain();
    endtask

    task automatic t_block();
        put(32'hA0A0, 32'h1, 0, 0, 0, 0);
        put(32'hB0B0, 32'h1, 0, 0, 0, 0);
        check("R4", "stall on full", 64'(stall), 64'h1);
        check("R4", "no done", 64'(op_done), 64'h0);
        repeat (3) @(negedge clk);
        check("R4", "still stalled", 64'(stall), 64'h1);
        check("R4", "old beat kept", 64'(m_tdata[1]), 64'hA0A0);
        rdy[1] = 1;
        @(negedge clk);
        rdy = 0;
        check("R4", "done on free", 64'(op_done), 64'h1);
        check("R4", "stall released", 64'(stall), 64'h0);
        check("R4", "new beat", 64'(m_tdata[1]), 64'hB0B0);
        check("R4", "new beat valid", 64'(m_tvalid[1]), 64'h1);
        drain();
    endtask

    task automatic t_nb();
        put(32'h3333, 32'h3, 1, 0, 0, 0);
        check("R5", "carry we", 64'(carry_we), 64'h1);
        check("R5", "carry 0 with space", 64'(carry_val), 64'h0);
        check("R5", "beat loaded", 64'(m_tvalid[3]), 64'h1);
        put(32'h4444, 32'h3, 1, 0, 0, 0);
        check("R5", "no stall when full", 64'(stall), 64'h0);
        check("R5", "carry 1 when full", 64'(carry_val), 64'h1);
        check("R5", "done when full", 64'(op_done), 64'h1);
        check("R5", "no load when full", 64'(m_tdata[3]), 64'h3333);
        rdy[3] = 1;
        put(32'h4444, 32'h3, 1, 0, 0, 0);
        rdy = 0;
        check("R5", "carry 0 while draining", 64'(carry_val), 64'h0);
        check("R5", "loaded while draining", 64'(m_tdata[3]), 64'h4444);
        drain();
    endtask

    task automatic t_test();
        put(32'h5555, 32'h0, 0, 0, 0, 0);
        put(32'h0, 32'h0, 1, 1, 1, 0);
        check("R6", "test carry full", 64'(carry_val), 64'h1);
        check("R6", "test keeps data", 64'(m_tdata[0]), 64'h5555);
        check("R6", "test keeps last", 64'(m_tlast[0]), 64'h0);
        drain();
        put(32'h0, 32'h0, 1, 1, 1, 0);
        check("R6", "test carry space", 64'(carry_val), 64'h0);
        check("R6", "test done", 64'(op_done), 64'h1);
        check("R6", "test no tvalid", 64'(m_tvalid), 64'h0);
    endtask

    task automatic t_illegal();
        put(32'h7777, 32'h5, 0, 0, 0, 0);
        check("R7", "trap", 64'(trap_req), 64'h1);
        check("R7", "cause", 64'(trap_cause), 64'h2);
        check("R7", "no done", 64'(op_done), 64'h0);
        check("R7", "no beat", 64'(m_tvalid), 64'h0);
    endtask

    task automatic t_atomic();
        put(32'h1, 32'h0, 0, 0, 0, 1);
        check("R8", "inhibit after atomic", 64'(irq_inhibit), 64'h1);
        @(negedge clk);
        check("R8", "inhibit held", 64'(irq_inhibit), 64'h1);
        insn_retire = 1;
        @(negedge clk);
        insn_retire = 0;
        check("R8", "inhibit cleared by retire", 64'(irq_inhibit), 64'h0);
        drain();
        put(32'h2, 32'h1, 0, 0, 0, 0);
        put(32'h3, 32'h1, 0, 0, 0, 1);
        check("R8", "inhibit while stalled", 64'(irq_inhibit), 64'h1);
        irq_req = 1;
        repeat (2) @(negedge clk);
        check("R8", "atomic not aborted", 64'(op_abort), 64'h0);
        check("R8", "atomic still stalled", 64'(stall), 64'h1);
        rdy[1] = 1;
        @(negedge clk);
        rdy = 0; irq_req = 0;
        check("R8", "atomic completes", 64'(op_done), 64'h1);
        check("R8", "atomic beat", 64'(m_tdata[1]), 64'h3);
        check("R8", "inhibit after stall", 64'(irq_inhibit), 64'h1);
        insn_retire = 1;
        @(negedge clk);
        insn_retire = 0;
        check("R8", "inhibit cleared", 64'(irq_inhibit), 64'h0);
        drain();
    endtask

    task automatic t_irq();
        put(32'h77, 32'h2, 0, 0, 0, 0);
        put(32'h88, 32'h2, 0, 0, 0, 0);
        irq_req = 1;
        @(negedge clk);
        irq_req = 0;
        check("R9", "abort", 64'(op_abort), 64'h1);
        check("R9", "stall dropped", 64'(stall), 64'h0);
        check("R9", "no done", 64'(op_done), 64'h0);
        check("R9", "old beat kept", 64'(m_tdata[2]), 64'h77);
        put(32'h99, 32'h2, 0, 0, 0, 0);
        check("R9", "stall again", 64'(stall), 64'h1);
        irq_req = 1; rdy[2] = 1;
        @(negedge clk);
        irq_req = 0; rdy = 0;
        check("R9", "free wins: done", 64'(op_done), 64'h1);
        check("R9", "free wins: no abort", 64'(op_abort), 64'h0);
        check("R9", "free wins: beat", 64'(m_tdata[2]), 64'h99);
        drain();
    endtask

    task automatic t_alt();
        a_valid = 1; a_rs1 = 16'h1234; a_rs2 = 16'h0; a_test = 1; a_atomic = 1;
        @(negedge clk);
        a_valid = 0; a_test = 0; a_atomic = 0;
        check("R11", "not done after one cycle", 64'(a_done), 64'h0);
        @(negedge clk);
        check("R11", "done after two cycles", 64'(a_done), 64'h1);
        check("R10", "test flag ignored", 64'(a_tvalid), 64'h1);
        check("R10", "data loaded", 64'(a_tdata[0]), 64'h1234);
        check("R10", "atomic flag ignored", 64'(a_inhibit), 64'h0);
        a_rdy = 2'b11;
        @(negedge clk);
        a_rdy = 0;
        a_valid = 1; a_rs1 = 16'h5678; a_rs2 = 16'h3;
        @(negedge clk);
        a_valid = 0;
        @(negedge clk);
        check("R7", "nop done", 64'(a_done), 64'h1);
        check("R7", "nop no trap", 64'(a_trap), 64'h0);
        check("R7", "nop no beat", 64'(a_tvalid), 64'h0);
    endtask

    initial begin
        #(4 * 100000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_block();
        t_nb();
        t_test();
        t_illegal();
        t_atomic();
        t_irq();
        t_alt();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule